// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block counts timebase ticks against a programmable 48-bit period. If software lets one whole period pass without a refresh, the block raises a warning level. It then starts a second period at once. If that second period also passes without a refresh, the block raises a reset-request level. The reset request stays set until the block's own asynchronous reset. Software services the timer by writing to a one-word refresh frame. Configuration, status and identification live in a separate control frame. Both frames sit on one simple register port, and a frame-select bit chooses between them.

A refresh and an expiry can fall in the same clock cycle. In that case the refresh wins: the warning ends clear, no escalation happens, and the period starts again from zero. Software can therefore schedule its refresh exactly at the warning deadline without losing it.

Top module: `dual_stage_wdog`

## Requirements
- R1: After the asynchronous reset, both flag outputs are low and the timer is disabled. The period reads back as 48'hFFFF_FFFF_FFFF: the low word reads 32'hFFFF_FFFF and the high word reads 32'h0000_FFFF. The status word reads zero.
- R2: While the timer is enabled and no refresh occurs, the warning output rises on the clock edge that samples the N-th asserted tick since the last refresh, where N is the programmed period. Cycles with `tick` low do not advance the count. A period of 0 behaves like a period of 1.
- R3: When a period expires while the warning is already high, the reset request rises, the warning stays high, and the count restarts.
- R4: A write of any data to address 0x000 in the refresh frame (`busFrame`=1) clears the warning and restarts the period from zero. A write to control-frame address 0x000, 0x008 or 0x00C does the same.
- R5: A refresh in the same cycle as an expiry takes priority. The warning ends low, the reset request is not raised, and the count restarts from zero.
- R6: Bit 0 of control address 0x000 is the enable bit. While it is clear, the count is frozen, the warning is held low, and the reset request cannot become set.
- R7: Once set, the reset request stays high through refreshes and through disabling. Only the asynchronous reset clears it.
- R8: The period is 48 bits wide. Control address 0x008 holds bits [31:0]. Control address 0x00C holds bits [47:32] in its bits [15:0]. Bits [31:16] of 0x00C read as zero.
- R9: A read of control address 0x000 returns the enable bit in bit 0, the warning in bit 1 and the reset request in bit 2. All other bits read zero.
- R10: Control address 0xFCC reads the version (default 4'h1) in bits [19:16] and the implementer code (default 11'h2A5) in bits [10:0], with zeros elsewhere. Unmapped addresses and every read of the refresh frame return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable; one count per high cycle |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busFrame | input | 1 | Frame select: 0 control, 1 refresh |
| busAddr | input | 12 | Byte address within the frame |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busFrame/busAddr |
| warnOut | output | 1 | First-stage warning level |
| resetReqOut | output | 1 | Second-stage reset request level |

## Verification
A count that drifts or misses a tick moves the warning edge off its expected cycle. A reference model that steps with every clock catches this on the first deadline after the fault. If the same-cycle refresh were dropped, the warning would stay high after the race cycle. The reset request would then rise one period later, and the check on the cycle right after the collision already exposes the fault. A wrong period decode or field placement shows up on the next readback of the period or status word, and it also shifts the deadline that follows.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] ADDR_CTRL  = 12'h000;
  localparam logic [BUS_AW-1:0] ADDR_OFFLO = 12'h008;
  localparam logic [BUS_AW-1:0] ADDR_OFFHI = 12'h00C;
  localparam logic [BUS_AW-1:0] ADDR_IDENT = 12'hFCC;
  localparam logic [BUS_AW-1:0] ADDR_KICK  = 12'h000;

  localparam int STAT_EN   = 0;
  localparam int STAT_WARN = 1;
  localparam int STAT_RST  = 2;

  typedef struct packed {
    logic              restart;
    logic              loadLo;
    logic              loadHi;
    logic [BUS_DW-1:0] data;
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int          CNT_W       = 48,
  parameter logic [3:0]  VERSION     = 4'h1,
  parameter logic [10:0] IMPLEMENTER = 11'h2A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busFrame,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [BUS_DW-1:0] busWrData,
  input  logic [CNT_W-1:0]  offsetVal,
  input  logic              warnState,
  input  logic              resetState,
  output logic              enable,
  output wdStrobe_t         strobe,
  output logic [BUS_DW-1:0] busRdData
);
  localparam int HI_W = CNT_W - BUS_DW;

  logic ctrlWr;
  logic kickWr;
  logic wrCtrlWord;
  logic wrLo;
  logic wrHi;

  assign ctrlWr     = busWrEn && !busFrame;
  assign kickWr     = busWrEn && busFrame && (busAddr == ADDR_KICK);
  assign wrCtrlWord = ctrlWr && (busAddr == ADDR_CTRL);
  assign wrLo       = ctrlWr && (busAddr == ADDR_OFFLO);
  assign wrHi       = ctrlWr && (busAddr == ADDR_OFFHI);

  always_comb begin
    strobe.restart = kickWr || wrCtrlWord || wrLo || wrHi;
    strobe.loadLo  = wrLo;
    strobe.loadHi  = wrHi;
    strobe.data    = busWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable <= 1'b0;
    else if (wrCtrlWord) enable <= busWrData[0];
  end

  logic [BUS_DW-1:0] identWord;
  logic [BUS_DW-1:0] statWord;
  logic [BUS_DW-1:0] hiWord;

  always_comb begin
    identWord = '0;
    identWord[19:16] = VERSION;
    identWord[10:0]  = IMPLEMENTER;
    statWord = '0;
    statWord[STAT_EN]   = enable;
    statWord[STAT_WARN] = warnState;
    statWord[STAT_RST]  = resetState;
    hiWord = '0;
    hiWord[HI_W-1:0] = offsetVal[CNT_W-1:BUS_DW];
  end

  always_comb begin
    busRdData = '0;
    if (!busFrame) begin
      unique case (busAddr)
        ADDR_CTRL:  busRdData = statWord;
        ADDR_OFFLO: busRdData = offsetVal[BUS_DW-1:0];
        ADDR_OFFHI: busRdData = hiWord;
        ADDR_IDENT: busRdData = identWord;
        default:    busRdData = '0;
      endcase
    end
  end

  // The enable level changes only on a control-word write.
  p_enable_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrCtrlWord |=> $stable(enable));
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  wdStrobe_t        strobe,
  output logic [CNT_W-1:0] offsetVal,
  output logic             warn,
  output logic             resetReq
);
  localparam int HI_W = CNT_W - BUS_DW;

  logic [CNT_W-1:0] count;
  logic [CNT_W:0]   nextCount;
  logic             expire;

  assign nextCount = {1'b0, count} + 1'b1;
  assign expire    = enable && tick && (nextCount >= {1'b0, offsetVal});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) offsetVal <= '1;
    else begin
      if (strobe.loadLo) offsetVal[BUS_DW-1:0]     <= strobe.data;
      if (strobe.loadHi) offsetVal[CNT_W-1:BUS_DW] <= strobe.data[HI_W-1:0];
    end
  end

  // The refresh is tested before the expiry, so a same-cycle refresh wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      warn  <= 1'b0;
    end else if (strobe.restart) begin
      count <= '0;
      warn  <= 1'b0;
    end else if (!enable) begin
      warn  <= 1'b0;
    end else if (tick) begin
      if (expire) begin
        count <= '0;
        warn  <= 1'b1;
      end else begin
        count <= nextCount[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resetReq <= 1'b0;
    else if (expire && warn && !strobe.restart) resetReq <= 1'b1;
  end

  p_refresh_clears_warn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.restart |=> !warn);

  p_race_refresh_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.restart && expire) |=> (!warn && (count == '0)));

  p_warn_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn) |-> $past(enable && tick));

  p_escalate_after_warn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetReq) |-> $past(warn));

  p_reset_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |=> resetReq);

  p_frozen_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !strobe.restart) |=> ($stable(count) && !warn));

  p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (offsetVal == '0) || (count < offsetVal));
endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
  import wdog_pkg::*;
#(
  parameter int          CNT_W       = 48,
  parameter logic [3:0]  VERSION     = 4'h1,
  parameter logic [10:0] IMPLEMENTER = 11'h2A5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        busWrEn,
  input  logic        busFrame,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        warnOut,
  output logic        resetReqOut
);
  wdStrobe_t        strobe;
  logic             enable;
  logic [CNT_W-1:0] offsetVal;
  logic             warn;
  logic             resetReq;

  wdog_ctrl #(.CNT_W(CNT_W), .VERSION(VERSION), .IMPLEMENTER(IMPLEMENTER)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busFrame(busFrame),
    .busAddr(busAddr), .busWrData(busWrData), .offsetVal(offsetVal),
    .warnState(warn), .resetState(resetReq), .enable(enable),
    .strobe(strobe), .busRdData(busRdData)
  );

  wdog_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(enable), .strobe(strobe),
    .offsetVal(offsetVal), .warn(warn), .resetReq(resetReq)
  );

  assign warnOut     = warn;
  assign resetReqOut = resetReq;
endmodule

// File: tb/dual_stage_wdog_test.sv
module dual_stage_wdog_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busFrame = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        warnOut;
  logic        resetReqOut;

  dual_stage_wdog uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busWrEn(busWrEn), .busFrame(busFrame),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .warnOut(warnOut), .resetReqOut(resetReqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  bit      mEn;
  longint  mOff;
  longint  mCnt;
  bit      mWarn;
  bit      mRst;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mEn = 0; mOff = 64'hFFFF_FFFF_FFFF; mCnt = 0; mWarn = 0; mRst = 0;
  endtask

  // One clock: reference update at the edge, output compare at the falling edge.
  task automatic step();
    bit kick;
    bit oldEn;
    @(posedge clk);
    oldEn = mEn;
    kick = busWrEn && ((busFrame && busAddr == 12'h000) ||
           (!busFrame && (busAddr == 12'h000 || busAddr == 12'h008 || busAddr == 12'h00C)));
    if (busWrEn && !busFrame && busAddr == 12'h000) mEn = busWrData[0];
    if (busWrEn && !busFrame && busAddr == 12'h008)
      mOff = (mOff & 64'hFFFF_0000_0000) | longint'(busWrData);
    if (busWrEn && !busFrame && busAddr == 12'h00C)
      mOff = (mOff & 64'h0000_FFFF_FFFF) | (longint'(busWrData[15:0]) << 32);
    if (kick) begin
      mCnt = 0; mWarn = 0;
    end else if (!oldEn) begin
      mWarn = 0;
    end else if (tick) begin
      if (mCnt + 1 >= mOffPrev) begin
        mCnt = 0;
        if (mWarn) mRst = 1; else mWarn = 1;
      end else mCnt++;
    end
    mOffPrev = mOff;
    @(negedge clk);
    chk("R2 R3 R5 R6 R7 warn trace", longint'(warnOut), longint'(mWarn));
    chk("R3 R7 reset trace", longint'(resetReqOut), longint'(mRst));
  endtask

  longint mOffPrev;

  task automatic wr(input bit frame, input logic [11:0] a, input logic [31:0] d);
    busWrEn = 1; busFrame = frame; busAddr = a; busWrData = d;
    step();
    busWrEn = 0; busFrame = 0; busAddr = 0; busWrData = 0;
  endtask

  task automatic rd(input string req, input bit frame, input logic [11:0] a, input longint exp);
    busFrame = frame; busAddr = a;
    #1;
    chk(req, longint'(busRdData), exp);
    busFrame = 0; busAddr = 0;
  endtask

  task automatic statExp(output longint v);
    v = longint'({mRst, mWarn, mEn});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    longint sv;
    int wcount;
    modelReset();
    mOffPrev = mOff;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 warn", longint'(warnOut), 0);
    chk("R1 reset", longint'(resetReqOut), 0);
    rd("R1 offset low", 0, 12'h008, 64'hFFFF_FFFF);
    rd("R1 offset high", 0, 12'h00C, 64'h0000_FFFF);
    rd("R1 status", 0, 12'h000, 0);
    rst_n = 1;
    // R10 identity and unmapped
    rd("R10 ident", 0, 12'hFCC, 64'h0001_02A5);
    rd("R10 unmapped", 0, 12'h004, 0);
    rd("R10 refresh frame read", 1, 12'h000, 0);
    // R8 48-bit period readback
    wr(0, 12'h00C, 32'hABCD_1234);
    rd("R8 high word", 0, 12'h00C, 64'h1234);
    wr(0, 12'h008, 32'h0000_0005);
    wr(0, 12'h00C, 32'h0);
    rd("R8 low word", 0, 12'h008, 5);
    // R6 disabled: ticks do nothing
    tick = 1;
    repeat (12) step();
    chk("R6 disabled no warn", longint'(warnOut), 0);
    // R2 enable and count to warning
    wr(0, 12'h000, 32'h1);
    wcount = 0;
    while (!warnOut && wcount < 20) begin step(); wcount++; end
    chk("R2 warn after period ticks", wcount, 5);
    statExp(sv);
    rd("R9 status with warn", 0, 12'h000, sv);
    // R4 refresh frame clears warning
    wr(1, 12'h000, 32'hDEAD_BEEF);
    chk("R4 refresh clears", longint'(warnOut), 0);
    // R2 gated ticks: every other cycle
    wcount = 0;
    while (!warnOut && wcount < 40) begin
      tick = wcount[0]; step(); wcount++;
    end
    chk("R2 gated tick deadline", wcount, 10);
    tick = 1;
    // R5 race: refresh on the exact expiry cycle
    while (mCnt + 1 < mOff) step();
    wr(1, 12'h000, 32'h0);
    chk("R5 race warn clear", longint'(warnOut), 0);
    chk("R5 race no escalation", longint'(resetReqOut), 0);
    // R4 control-frame writes also restart
    repeat (3) step();
    wr(0, 12'h008, 32'h5);
    repeat (4) step();
    chk("R4 offset write restarts", longint'(warnOut), 0);
    step();
    chk("R4 deadline after restart", longint'(warnOut), 1);
    // R6 disable clears warning, freezes
    wr(0, 12'h000, 32'h0);
    chk("R6 warn low when off", longint'(warnOut), 0);
    repeat (20) step();
    chk("R6 no escalation when off", longint'(resetReqOut), 0);
    // R3 escalation
    wr(0, 12'h000, 32'h1);
    repeat (10) step();
    chk("R3 reset request", longint'(resetReqOut), 1);
    chk("R3 warn held", longint'(warnOut), 1);
    statExp(sv);
    rd("R9 status escalated", 0, 12'h000, sv);
    // R7 sticky through refresh and disable
    wr(1, 12'h000, 32'h0);
    wr(0, 12'h000, 32'h0);
    repeat (3) step();
    chk("R7 sticky", longint'(resetReqOut), 1);
    // period 0 acts as 1 (R2)
    wr(0, 12'h008, 32'h0);
    wr(0, 12'h000, 32'h1);
    step();
    chk("R2 zero period", longint'(warnOut), 1);
    // R7 async reset clears
    rst_n = 0; modelReset(); mOffPrev = mOff;
    #1;
    chk("R7 cleared by reset", longint'(resetReqOut), 0);
    @(negedge clk);
    rst_n = 1;
    step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule